// File: doc/BRIEF.md
# Sum-of-products output macrocell (combinational mode)

This block models one output cell of a small sum-of-products programmable logic device. The cell works only in its combinational mode. A vector of array signals comes in, and each signal is also used in complemented form. A fuse map decides which of these literals take part in each of seven product terms.

Term 0 drives the pin's output enable. Terms 1 to 6 are ORed together, and the sum passes through a programmable polarity stage before it reaches the pin. The cell also returns a feedback signal to the array. When the cell drives its pin, the feedback is the driven value. When the pin is released, the feedback is the value that something outside drives onto the pin.

A parameter removes the pin input path for the cells at the two ends of a row. These cells are output-only, so their feedback is held at 0. Control-bit combinations other than the combinational mode raise a flag and keep the pin released. The block has no clock and no state.

Top module: `pld_olmc`

## Requirements
- R1: Fuses are laid out as `fuse_map[p*2*N_IN + c]` for term p. Column c = 2i reads `arr_in[i]` and column c = 2i+1 reads `~arr_in[i]`. A fuse bit of 1 means intact, and only intact columns are ANDed into the term. A term with every fuse intact is always false.
- R2: A term whose fuses are all blown (all 0) is always true.
- R3: `pin_oe` is 1 exactly when term 0 is true and the mode is supported.
- R4: The level before the polarity stage is the OR of terms 1 to 6, so one true term among them is enough to set it.
- R5: With `cfg_xor`=1, `pin_out` equals that OR level (active high). With `cfg_xor`=0, `pin_out` is its inverse (active low).
- R6: `cfg_ac1` has no effect on any output while `cfg_syn`=1 and `cfg_ac0`=1.
- R7: If `cfg_syn` or `cfg_ac0` is 0, `mode_unsupported` is 1 and `pin_oe` is 0. Otherwise `mode_unsupported` is 0.
- R8: With feedback present and `pin_oe`=1, `fb_out` equals `pin_out`.
- R9: With feedback present and `pin_oe`=0, `fb_out` equals `pin_ext`.
- R10: With `HAS_FEEDBACK`=0, `fb_out` is always 0. The pin and enable outputs behave exactly as in a cell with feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arr_in | input | N_IN | True-polarity array signals |
| fuse_map | input | PT_COUNT*2*N_IN | Product-term fuse bits, 1 = intact |
| cfg_syn | input | 1 | Mode control bit, must be 1 for combinational mode |
| cfg_ac0 | input | 1 | Mode control bit, must be 1 for combinational mode |
| cfg_ac1 | input | 1 | Mode control bit, ignored in combinational mode |
| cfg_xor | input | 1 | Polarity: 1 active high, 0 active low |
| pin_ext | input | 1 | Value driven onto the pin from outside |
| pin_out | output | 1 | Value the cell drives onto the pin |
| pin_oe | output | 1 | Output enable of the pin driver |
| fb_out | output | 1 | Feedback into the array |
| mode_unsupported | output | 1 | Control bits select a mode that is not modelled |

## Verification
Two functions can meet in the same evaluation. In one, the enable term releases the pin while the sum and polarity still produce a level, so the feedback has to switch from the driven value to the external value. In the other, an unsupported mode overrides a true enable term. The bench provokes both with sparse pseudo-random fuse maps that make the enable and sum terms fall true and false independently. Each map is swept over every input value, both polarities and both external pin levels, with the ignored control bit toggled throughout. Each output is judged against arithmetic expectations. An output-only cell runs on the same stimulus, so its pin outputs can be compared with the main cell's and its feedback checked against zero.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

   typedef enum logic [0:0] {
      MC_COMBO   = 1'b0,
      MC_UNKNOWN = 1'b1
   } mc_mode_e;

   // Decode the architecture bits; the third bit does not matter in combo mode.
   function automatic mc_mode_e mc_decode(input logic syn, input logic ac0, input logic ac1);
      mc_mode_e m;
      casez ({syn, ac0, ac1})
         3'b11?:  m = MC_COMBO;
         default: m = MC_UNKNOWN;
      endcase
      return m;
   endfunction

   // Literal value for one array column: even columns true, odd complemented.
   function automatic logic mc_literal(input logic sig, input logic odd_col);
      return odd_col ? ~sig : sig;
   endfunction

endpackage

// File: rtl/pld_pterm.sv
module pld_pterm #(
   parameter int N_IN = 4,
   localparam int N_COL = 2 * N_IN
) (
   input  logic [N_IN-1:0]  arr_in,
   input  logic [N_COL-1:0] fuses,
   output logic             term
);
   import pld_mc_pkg::*;

   logic [N_COL-1:0] lit_ok;

   for (genvar c = 0; c < N_COL; c++) begin : g_col
      // A blown fuse leaves the column out of the AND.
      assign lit_ok[c] = ~fuses[c] | mc_literal(arr_in[c/2], (c % 2) == 1);
   end

   assign term = &lit_ok;
endmodule

// File: rtl/pld_sum_pol.sv
module pld_sum_pol #(
   parameter int N_SUM = 6
) (
   input  logic [N_SUM-1:0] terms,
   input  logic             pol_high,
   output logic             level
);
   logic sum_or;

   assign sum_or = |terms;
   assign level  = pol_high ? sum_or : ~sum_or;
endmodule

// File: rtl/pld_fb_path.sv
module pld_fb_path #(
   parameter bit HAS_FEEDBACK = 1'b1
) (
   input  logic drive_val,
   input  logic drive_en,
   input  logic ext_val,
   output logic fb
);
   if (HAS_FEEDBACK) begin : g_fb
      assign fb = drive_en ? drive_val : ext_val;
   end else begin : g_nofb
      assign fb = 1'b0;
   end
endmodule

// File: rtl/pld_olmc.sv
module pld_olmc #(
   parameter int N_IN         = 4,
   parameter int PT_COUNT     = 7,
   parameter bit HAS_FEEDBACK = 1'b1,
   localparam int N_COL  = 2 * N_IN,
   localparam int N_SUM  = PT_COUNT - 1,
   localparam int FUSE_W = PT_COUNT * N_COL
) (
   input  logic [N_IN-1:0]   arr_in,
   input  logic [FUSE_W-1:0] fuse_map,
   input  logic              cfg_syn,
   input  logic              cfg_ac0,
   input  logic              cfg_ac1,
   input  logic              cfg_xor,
   input  logic              pin_ext,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              fb_out,
   output logic              mode_unsupported
);
   import pld_mc_pkg::*;

   if (N_IN < 1) begin : g_bad_nin
      $error("pld_olmc: N_IN must be at least 1");
   end
   if (PT_COUNT < 2) begin : g_bad_pt
      $error("pld_olmc: PT_COUNT must leave one enable term and one sum term");
   end

   mc_mode_e         mode;
   logic [PT_COUNT-1:0] pt;
   logic             level;

   assign mode = mc_decode(cfg_syn, cfg_ac0, cfg_ac1);

   for (genvar p = 0; p < PT_COUNT; p++) begin : g_pt
      pld_pterm #(.N_IN(N_IN)) u_pt (
         .arr_in (arr_in),
         .fuses  (fuse_map[p*N_COL +: N_COL]),
         .term   (pt[p])
      );
   end

   pld_sum_pol #(.N_SUM(N_SUM)) u_sum (
      .terms    (pt[PT_COUNT-1:1]),
      .pol_high (cfg_xor),
      .level    (level)
   );

   assign mode_unsupported = (mode != MC_COMBO);
   assign pin_out          = level;
   assign pin_oe           = pt[0] & (mode == MC_COMBO);

   pld_fb_path #(.HAS_FEEDBACK(HAS_FEEDBACK)) u_fb (
      .drive_val (level),
      .drive_en  (pin_oe),
      .ext_val   (pin_ext),
      .fb        (fb_out)
   );
endmodule

// File: rtl/pld_olmc_chk.sv
module pld_olmc_chk #(
   parameter int N_IN         = 4,
   parameter int PT_COUNT     = 7,
   parameter bit HAS_FEEDBACK = 1'b1,
   localparam int N_COL  = 2 * N_IN,
   localparam int FUSE_W = PT_COUNT * N_COL
) (
   input logic [FUSE_W-1:0] fuse_map,
   input logic              cfg_syn,
   input logic              cfg_ac0,
   input logic              pin_ext,
   input logic              pin_out,
   input logic              pin_oe,
   input logic              fb_out,
   input logic              mode_unsupported
);
   always_comb begin
      AST_OE_SUPPORTED: assert (!(pin_oe && mode_unsupported)) else $error("enable in unsupported mode"); // R7
      AST_UNSUP_NO_OE: assert (!(!(cfg_syn && cfg_ac0) && pin_oe)) else $error("enable with bad mode bits"); // R7
      AST_INTACT_PT_FALSE: assert (!((&fuse_map[N_COL-1:0]) && pin_oe)) else $error("all-intact term true"); // R1
      AST_BLOWN_PT_TRUE: assert (!((fuse_map[N_COL-1:0] == '0) && cfg_syn && cfg_ac0 && !pin_oe)) else $error("blown term false"); // R2
      if (HAS_FEEDBACK) begin
         AST_FB_DRIVEN: assert (!pin_oe || fb_out == pin_out) else $error("feedback not driven value"); // R8
         AST_FB_EXTERNAL: assert (pin_oe || fb_out == pin_ext) else $error("feedback not pin value"); // R9
      end else begin
         AST_FB_ABSENT: assert (fb_out == 1'b0) else $error("output-only cell feeds back"); // R10
      end
   end
endmodule

bind pld_olmc pld_olmc_chk #(
   .N_IN(N_IN), .PT_COUNT(PT_COUNT), .HAS_FEEDBACK(HAS_FEEDBACK)
) u_chk (
   .fuse_map(fuse_map), .cfg_syn(cfg_syn), .cfg_ac0(cfg_ac0),
   .pin_ext(pin_ext), .pin_out(pin_out), .pin_oe(pin_oe),
   .fb_out(fb_out), .mode_unsupported(mode_unsupported)
);

// File: tb/pld_olmc_tb.sv
module pld_olmc_tb;
   localparam int N_IN = 4;
   localparam int PT   = 7;
   localparam int NCOL = 2 * N_IN;
   localparam int FW   = PT * NCOL;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [N_IN-1:0] arr_in = '0;
   logic [FW-1:0]   fuse_map = '1;
   logic syn = 1'b1, ac0 = 1'b1, ac1 = 1'b0, xr = 1'b1, pin_ext = 1'b0;
   logic pin_out, pin_oe, fb_out, unsup;
   logic e_out, e_oe, e_fb, e_unsup;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   pld_olmc #(.N_IN(N_IN), .PT_COUNT(PT), .HAS_FEEDBACK(1'b1)) u_dut (
      .arr_in(arr_in), .fuse_map(fuse_map), .cfg_syn(syn), .cfg_ac0(ac0),
      .cfg_ac1(ac1), .cfg_xor(xr), .pin_ext(pin_ext), .pin_out(pin_out),
      .pin_oe(pin_oe), .fb_out(fb_out), .mode_unsupported(unsup));

   pld_olmc #(.N_IN(N_IN), .PT_COUNT(PT), .HAS_FEEDBACK(1'b0)) u_edge (
      .arr_in(arr_in), .fuse_map(fuse_map), .cfg_syn(syn), .cfg_ac0(ac0),
      .cfg_ac1(ac1), .cfg_xor(xr), .pin_ext(pin_ext), .pin_out(e_out),
      .pin_oe(e_oe), .fb_out(e_fb), .mode_unsupported(e_unsup));

   function automatic logic [63:0] next_rng(input logic [63:0] s);
      logic [63:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   function automatic logic exp_term(input int p, input logic [N_IN-1:0] a, input logic [FW-1:0] f);
      logic r = 1'b1;
      for (int c = 0; c < NCOL; c++) begin
         if (f[p*NCOL + c]) r = r & ((c % 2 == 1) ? ~a[c/2] : a[c/2]);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic act, input logic expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b (in=%h xor=%0b ext=%0b)", req, act, expv, arr_in, xr, pin_ext);
      end
   endtask

   task automatic check_all(input logic syn_v, input logic ac0_v);
      logic ok, oe, sum, lvl, fb;
      ok  = syn_v & ac0_v;
      oe  = exp_term(0, arr_in, fuse_map) & ok;
      sum = 1'b0;
      for (int p = 1; p < PT; p++) sum = sum | exp_term(p, arr_in, fuse_map);
      lvl = xr ? sum : ~sum;
      fb  = oe ? lvl : pin_ext;
      chk("R3 enable", pin_oe, oe);
      chk("R7 flag", unsup, ~ok);
      if (ok) chk("R4/R5 pin level", pin_out, lvl);
      if (ok) chk(oe ? "R8 fb driven" : "R9 fb external", fb_out, fb);
      chk("R10 edge fb zero", e_fb, 1'b0);
      chk("R10 edge enable", e_oe, oe);
      if (ok) chk("R10 edge pin", e_out, lvl);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [6:0] save_out;
      // Start state: every fuse intact, so no term is ever true.
      @(negedge clk);
      chk("R1 start enable", pin_oe, 1'b0);
      chk("R1 start pin active-high", pin_out, 1'b0);
      chk("R7 start flag", unsup, 1'b0);

      // R1: all-intact enable term false for every input.
      for (int v = 0; v < (1 << N_IN); v++) begin
         @(posedge clk); arr_in = v[N_IN-1:0];
         @(negedge clk); chk("R1 all intact", pin_oe, 1'b0);
      end

      // R2: all-blown enable term true for every input.
      fuse_map = '0;
      for (int v = 0; v < (1 << N_IN); v++) begin
         @(posedge clk); arr_in = v[N_IN-1:0];
         @(negedge clk); chk("R2 all blown", pin_oe, 1'b1);
      end

      // R4: a single true sum term out of six, each in turn.
      for (int p = 1; p < PT; p++) begin
         @(posedge clk);
         fuse_map = '1;
         fuse_map[p*NCOL +: NCOL] = '0;
         fuse_map[0 +: NCOL] = '0;
         xr = 1'b1;
         @(negedge clk); chk("R4 single sum term", pin_out, 1'b1);
         @(posedge clk); xr = 1'b0;
         @(negedge clk); chk("R5 active low", pin_out, 1'b0);
      end

      // Sweeps over sparse random fuse maps.
      for (int pat = 0; pat < 160; pat++) begin
         logic [63:0] r1, r2, r3;
         rng = next_rng(rng); r1 = rng;
         rng = next_rng(rng); r2 = rng;
         rng = next_rng(rng); r3 = rng;
         @(posedge clk);
         fuse_map = r1[FW-1:0] & r2[FW-1:0] & r3[FW-1:0];
         if (pat % 4 == 0) fuse_map[0 +: NCOL] = '0;
         for (int v = 0; v < (1 << N_IN); v++) begin
            for (int k = 0; k < 4; k++) begin
               @(posedge clk);
               arr_in = v[N_IN-1:0]; xr = k[0]; pin_ext = k[1];
               syn = 1'b1; ac0 = 1'b1; ac1 = 1'b0;
               @(negedge clk);
               check_all(1'b1, 1'b1);
               save_out = {pin_out, pin_oe, fb_out, unsup, e_out, e_oe, e_fb};
               @(posedge clk); ac1 = 1'b1;
               @(negedge clk);
               checks++;
               if ({pin_out, pin_oe, fb_out, unsup, e_out, e_oe, e_fb} !== save_out) begin
                  fails++;
                  $display("FAIL R6 ac1 effect: actual %b expected %b",
                           {pin_out, pin_oe, fb_out, unsup, e_out, e_oe, e_fb}, save_out);
               end
               if (k == 0) begin
                  for (int m = 0; m < 3; m++) begin
                     @(posedge clk); syn = m[1]; ac0 = m[0];
                     @(negedge clk); check_all(m[1], m[0]);
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule